// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller for a parameterised number of pins, a multiple of 32. Software reaches it over a simple 32-bit register bus. Through that bus it sets each pin's direction and drives output values with write-one set and clear words. It reads back the synchronised pad levels. It chooses, pin by pin, whether rising edges, falling edges or both latch an edge-status bit. Any pending status bit raises a single combined interrupt line.

Registers are grouped by family. Each family takes NGPIO/32 consecutive 32-bit words, and pin p lives in word p/32 of its family at bit p mod 32. Pad inputs pass through a two-flop synchroniser. Edge detection compares the synchronised level with its value one cycle earlier. Reads return data on the clock after the access.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Word index (bus_addr[7:2] at the defaults) equals family × (NGPIO/32) + pin/32, with family codes level=0, direction=1, set=2, clear=3, rise-enable=4, fall-enable=5, edge-status=6. The pin occupies bit pin mod 32 of that word, and bus_addr[1:0] is ignored.
- R2: A read of the level family returns the pad inputs after a two-flop synchroniser. Writes to the level family change nothing.
- R3: A write to the direction family replaces the whole word, and a read returns it. pad_oe bit = 1 makes that pin an output.
- R4: Writing 1s to the set family drives those pad_out bits high, and writing 1s to the clear family drives them low. Bits written as 0 keep their value, and reads of both families return 0.
- R5: When a pin's rise-enable bit is 1, a 0-to-1 change of its synchronised level sets its edge-status bit.
- R6: When a pin's fall-enable bit is 1, a 1-to-0 change sets its edge-status bit. An edge whose enable is 0 sets nothing.
- R7: Writing 1 to an edge-status bit clears it, and 0 bits leave status unchanged. If an enabled edge arrives in the same cycle as the clearing write, the bit stays set.
- R8: irq is 1 exactly while at least one edge-status bit is set.
- R9: Accesses with word index ≥ 7 × (NGPIO/32) read 0 and change no state.
- R10: After reset, direction is all inputs, outputs are 0, both edge enables are 0, edge status is 0, irq is 0 and bus_rdata is 0.
- R11: Read data appears on bus_rdata on the clock edge that samples the read, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | NGPIO | Asynchronous pad input levels |
| pad_out | output | NGPIO | Pad output values |
| pad_oe | output | NGPIO | Pad output enables (1 = drive) |
| irq | output | 1 | Combined edge interrupt |

## Verification
The assertions assume that rst_n is deasserted synchronously to clk. They also assume that bus_sel, bus_wr, bus_addr and bus_wdata are stable around the sampling edge, and that a single access is one cycle long. The stimulus drives every input on the falling clock edge and releases reset that way too. After a pad change it leaves the bus idle for four cycles, so each edge is latched against settled enables. The only exception is one directed case, which deliberately lines up a clearing write with the cycle in which an edge is latched.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int BUS_W     = 32;
  localparam int FAM_COUNT = 7;

  typedef enum logic [2:0] {
    FAM_LEVEL = 3'd0,
    FAM_DIR   = 3'd1,
    FAM_SET   = 3'd2,
    FAM_CLR   = 3'd3,
    FAM_RISE  = 3'd4,
    FAM_FALL  = 3'd5,
    FAM_STAT  = 3'd6
  } fam_e;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_pkg::*;
#(
  parameter int NW     = 2,
  parameter int WORD_W = 6,
  localparam int WIDX_W = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic [WORD_W-1:0] word_i,
  output fam_e              fam_o,
  output logic [WIDX_W-1:0] widx_o,
  output logic              hit_o
);
  always_comb begin
    int rel;
    fam_o  = FAM_LEVEL;
    widx_o = '0;
    hit_o  = 1'b0;
    rel    = 0;
    for (int f = 0; f < FAM_COUNT; f++) begin
      if ((int'(word_i) >= f * NW) && (int'(word_i) < (f + 1) * NW)) begin
        rel    = int'(word_i) - f * NW;
        hit_o  = 1'b1;
        fam_o  = fam_e'(3'(f));
        widx_o = rel[WIDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/gpio_sync_bank.sv
module gpio_sync_bank #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, meta_d;
  logic [W-1:0] sync_q, sync_d;

  always_comb begin
    meta_d = d_i;
    sync_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_edge_word.sv
module gpio_edge_word
  import gpio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] lvl_i,
  input  logic [BUS_W-1:0] rise_en_i,
  input  logic [BUS_W-1:0] fall_en_i,
  input  logic             clr_we_i,
  input  logic [BUS_W-1:0] clr_mask_i,
  output logic [BUS_W-1:0] stat_o
);
  logic [BUS_W-1:0] prev_q, prev_d;
  logic [BUS_W-1:0] stat_q, stat_d;
  logic [BUS_W-1:0] hits, clr_bits;

  always_comb begin
    prev_d   = lvl_i;
    hits     = (rise_en_i & lvl_i & ~prev_q) | (fall_en_i & ~lvl_i & prev_q);
    clr_bits = clr_we_i ? clr_mask_i : '0;
    // a fresh edge overrides a clear landing in the same cycle
    stat_d   = (stat_q & ~clr_bits) | hits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= prev_d;
      stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_pkg::*;
#(
  parameter int NGPIO  = 64,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NGPIO-1:0]  pad_in,
  output logic [NGPIO-1:0]  pad_out,
  output logic [NGPIO-1:0]  pad_oe,
  output logic              irq
);
  localparam int NW     = NGPIO / BUS_W;
  localparam int WORD_W = ADDR_W - 2;
  localparam int WIDX_W = (NW > 1) ? $clog2(NW) : 1;

  logic [NW-1:0][BUS_W-1:0] dir_q, dir_d;
  logic [NW-1:0][BUS_W-1:0] out_q, out_d;
  logic [NW-1:0][BUS_W-1:0] rise_q, rise_d;
  logic [NW-1:0][BUS_W-1:0] fall_q, fall_d;
  logic [NW-1:0][BUS_W-1:0] lvl_w;
  logic [NW-1:0][BUS_W-1:0] stat_w;
  logic [NW-1:0]            stat_clr;
  logic [NGPIO-1:0]         lvl_sync;
  logic [BUS_W-1:0]         rdata_q, rdata_d, rd_val;

  fam_e              fam;
  logic [WIDX_W-1:0] widx;
  logic              hit;
  logic              wr_ok, rd_ok;
  logic [1:0]        unused_byte_lane;

  assign unused_byte_lane = bus_addr[1:0];

  gpio_addr_dec #(.NW(NW), .WORD_W(WORD_W)) u_dec (
    .word_i (bus_addr[ADDR_W-1:2]),
    .fam_o  (fam),
    .widx_o (widx),
    .hit_o  (hit)
  );

  gpio_sync_bank #(.W(NGPIO)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pad_in),
    .q_o   (lvl_sync)
  );

  assign lvl_w = lvl_sync;
  assign wr_ok = bus_sel && bus_wr && hit;
  assign rd_ok = bus_sel && !bus_wr;

  for (genvar w = 0; w < NW; w++) begin : g_word
    assign stat_clr[w] = wr_ok && (fam == FAM_STAT) && (widx == WIDX_W'(w));

    gpio_edge_word u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl_i      (lvl_w[w]),
      .rise_en_i  (rise_q[w]),
      .fall_en_i  (fall_q[w]),
      .clr_we_i   (stat_clr[w]),
      .clr_mask_i (bus_wdata),
      .stat_o     (stat_w[w])
    );
  end

  // next-state for software-owned registers
  always_comb begin
    dir_d  = dir_q;
    out_d  = out_q;
    rise_d = rise_q;
    fall_d = fall_q;
    if (wr_ok) begin
      unique case (fam)
        FAM_DIR:  dir_d[widx]  = bus_wdata;
        FAM_SET:  out_d[widx]  = out_q[widx] | bus_wdata;
        FAM_CLR:  out_d[widx]  = out_q[widx] & ~bus_wdata;
        FAM_RISE: rise_d[widx] = bus_wdata;
        FAM_FALL: fall_d[widx] = bus_wdata;
        default:  ;
      endcase
    end
  end

  // read mux
  always_comb begin
    rd_val = '0;
    if (hit) begin
      unique case (fam)
        FAM_LEVEL: rd_val = lvl_w[widx];
        FAM_DIR:   rd_val = dir_q[widx];
        FAM_RISE:  rd_val = rise_q[widx];
        FAM_FALL:  rd_val = fall_q[widx];
        FAM_STAT:  rd_val = stat_w[widx];
        default:   rd_val = '0;
      endcase
    end
    rdata_d = rd_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else if (wr_ok) begin
      dir_q  <= dir_d;
      out_q  <= out_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_ok) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign pad_out   = out_q;
  assign pad_oe    = dir_q;
  assign irq       = |stat_w;
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int NGPIO  = 64,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [NGPIO-1:0]  pad_out,
  input logic [NGPIO-1:0]  pad_oe,
  input logic              irq
);
  localparam int NW     = NGPIO / 32;
  localparam int WORD_W = ADDR_W - 2;

  logic is_set0, is_clr0, any_wr, any_rd;
  assign is_set0 = bus_addr[ADDR_W-1:2] == WORD_W'(2 * NW);
  assign is_clr0 = bus_addr[ADDR_W-1:2] == WORD_W'(3 * NW);
  assign any_wr  = bus_sel && bus_wr;
  assign any_rd  = bus_sel && !bus_wr;

  p_reset_r10: assert property (@(posedge clk)
    $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0 && !irq && bus_rdata == '0));

  p_oe_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !any_wr |=> $stable(pad_oe));

  p_out_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !any_wr |=> $stable(pad_out));

  p_set_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr && is_set0) |=> ((pad_out[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

  p_clr_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr && is_clr0) |=> ((pad_out[31:0] & $past(bus_wdata)) == '0));

  p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(any_wr));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !any_rd |=> $stable(bus_rdata));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NGPIO(NGPIO), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .irq       (irq)
);

// File: tb/sim_gpio_bank_ctrl.sv
module sim_gpio_bank_ctrl;
  localparam int NG = 64;
  localparam int NW = NG / 32;
  localparam int NFW = 7 * NW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NG-1:0] pad_in = '0;
  logic [NG-1:0] pad_out, pad_oe;
  logic irq;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [NG-1:0] m_dir = '0, m_out = '0, m_re = '0, m_fe = '0, m_st = '0, m_pad = '0;

  always #5 clk = ~clk;

  gpio_bank_ctrl #(.NGPIO(NG), .ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  function automatic logic [7:0] waddr(int fam, int w);
    return 8'((fam * NW + w) * 4);
  endfunction

  function automatic logic [31:0] exp_rd(int word);
    int f, w;
    if (word >= NFW) return '0;
    f = word / NW;
    w = word % NW;
    case (f)
      0: return m_pad[w*32 +: 32];
      1: return m_dir[w*32 +: 32];
      4: return m_re[w*32 +: 32];
      5: return m_fe[w*32 +: 32];
      6: return m_st[w*32 +: 32];
      default: return '0;
    endcase
  endfunction

  function automatic void model_wr(int word, logic [31:0] d);
    int f, w;
    if (word >= NFW) return;
    f = word / NW;
    w = word % NW;
    case (f)
      1: m_dir[w*32 +: 32] = d;
      2: m_out[w*32 +: 32] = m_out[w*32 +: 32] | d;
      3: m_out[w*32 +: 32] = m_out[w*32 +: 32] & ~d;
      4: m_re[w*32 +: 32] = d;
      5: m_fe[w*32 +: 32] = d;
      6: m_st[w*32 +: 32] = m_st[w*32 +: 32] & ~d;
      default: ;
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    model_wr(int'(a[7:2]), d);
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic set_pad(logic [NG-1:0] v);
    @(negedge clk);
    pad_in = v;
    m_st = m_st | (m_re & v & ~m_pad) | (m_fe & ~v & m_pad);
    m_pad = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd_chk(string req, int word);
    logic [31:0] d;
    bus_read(8'(word * 4), d);
    chk(req, {32'd0, d}, {32'd0, exp_rd(word)});
  endtask

  task automatic check_all(string req);
    for (int wd = 0; wd < NFW; wd++) rd_chk(req, wd);
    chk({req, " R3 pad_oe"}, pad_oe, m_dir);
    chk({req, " R4 pad_out"}, pad_out, m_out);
    chk({req, " R8 irq"}, {63'd0, irq}, {63'd0, |m_st});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 pad_oe", pad_oe, '0);
    chk("R10 pad_out", pad_out, '0);
    chk("R10 irq", {63'd0, irq}, '0);
    chk("R10 rdata", {32'd0, bus_rdata}, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R10 regs");

    // R1 / R3 layout and direction
    bus_write(waddr(1, 1), 32'hA5A5_0001);
    chk("R1 R3 dir word1 to pad_oe", pad_oe, {32'hA5A5_0001, 32'h0});
    bus_write(waddr(1, 0) + 8'd2, 32'h0000_F00F);
    chk("R1 byte lane ignored", pad_oe, {32'hA5A5_0001, 32'h0000_F00F});
    rd_chk("R3 dir readback", NW + 1);

    // R4 set / clear
    bus_write(waddr(2, 0), 32'h0000_00F0);
    bus_write(waddr(3, 0), 32'h0000_0030);
    chk("R4 set then clear", pad_out, {32'h0, 32'h0000_00C0});
    bus_write(waddr(2, 1), 32'h8000_0000);
    chk("R1 R4 pin63", pad_out, {32'h8000_0000, 32'h0000_00C0});
    rd_chk("R4 set reads 0", 2 * NW);
    rd_chk("R4 clear reads 0", 3 * NW + 1);

    // R2 level
    set_pad(64'h1234_5678_9ABC_DEF0);
    rd_chk("R2 level word0", 0);
    rd_chk("R2 level word1", 1);
    bus_write(waddr(0, 0), 32'hFFFF_FFFF);
    rd_chk("R2 level write ignored", 0);

    // R5 / R6 edges
    set_pad('0);
    bus_write(waddr(6, 0), '1);
    bus_write(waddr(6, 1), '1);
    bus_write(waddr(4, 0), 32'h0000_0008);
    bus_write(waddr(5, 1), 32'h0000_0100);
    chk("R8 irq low", {63'd0, irq}, '0);
    set_pad(64'h0000_0100_0000_0009);
    rd_chk("R5 rise latched bit3 only", 6 * NW);
    rd_chk("R6 rise on fall-only pin ignored", 6 * NW + 1);
    chk("R8 irq high", {63'd0, irq}, 64'd1);
    set_pad(64'h0);
    rd_chk("R6 fall latched pin40", 6 * NW + 1);
    rd_chk("R5 fall on rise-only pin ignored", 6 * NW);

    // R7 partial clear
    bus_write(waddr(6, 0), 32'h0000_0001);
    rd_chk("R7 zero bits keep status", 6 * NW);
    bus_write(waddr(6, 0), 32'h0000_0008);
    rd_chk("R7 w1c clears", 6 * NW);
    chk("R8 irq still high", {63'd0, irq}, 64'd1);
    bus_write(waddr(6, 1), 32'h0000_0100);
    chk("R8 irq low after clear", {63'd0, irq}, '0);

    // R7 same-cycle edge beats clear (pin 5)
    bus_write(waddr(4, 0), 32'h0000_0020);
    bus_write(waddr(5, 0), 32'h0000_0020);
    set_pad(64'h20);
    rd_chk("R7 pre-set", 6 * NW);
    @(negedge clk);
    pad_in = 64'h0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = waddr(6, 0); bus_wdata = 32'h20;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    m_pad = '0;
    repeat (3) @(negedge clk);
    rd_chk("R7 edge wins over clear", 6 * NW);
    bus_write(waddr(6, 0), 32'h20);
    rd_chk("R7 later clear", 6 * NW);

    // R9 out of range
    bus_write(8'(NFW * 4), '1);
    bus_write(8'hFC, '1);
    rd_chk("R9 out of range read", NFW);
    check_all("R9 no state change");

    // R11 hold
    bus_read(waddr(1, 1), d);
    bus_write(waddr(2, 0), 32'h1);
    bus_write(waddr(1, 1), 32'h0);
    chk("R11 rdata holds", {32'd0, bus_rdata}, {32'd0, 32'hA5A5_0001});

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom % 4);
      if (op == 0) begin
        bus_write(8'(($urandom % 16) * 4), $urandom);
      end else if (op == 1) begin
        set_pad({$urandom, $urandom});
      end else if (op == 2) begin
        rd_chk("R1 R2 R5 R6 R9 random read", int'($urandom % 16));
      end else begin
        bus_write(waddr(int'($urandom % 7), int'($urandom % NW)), $urandom & $urandom);
      end
    end
    check_all("R1 R7 random final");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule